// File: doc/BRIEF.md
# Five-Channel Auto-Reload Down-Counter Bank

This block holds five 32-bit down counters. Each counter advances on its own tick input, which comes from a separate prescaler. Software controls the bank through a 32-bit register port with a write strobe and a combinational read. Each channel has three registers:
- a count buffer, which holds the value loaded into the counter;
- a compare buffer, which is plain storage on channels 0 to 3 and absent on channel 4;
- a read-only observation register, which returns the live count.

One shared control register holds four kinds of per-channel flag: run, load, invert and reload. Channel 4 has no invert flag.

A tick that arrives while a channel runs and its counter holds zero is an expiry. The expiry produces a one-cycle pulse on that channel's expiry output, for use by an interrupt block. The channel then either reloads from its count buffer and keeps going, or it stops and drops its run flag. Two prescaler configuration words are also kept as plain read/write storage for the neighbouring prescaler.

Top module: `dcb_bank`

## Requirements
- R1: After reset, the control register, all count and compare buffers and all live counts read 0, all channels are stopped, and every expiry output is 0. The first configuration word (offset 0x00) reads 0x00000101 and the second (0x04) reads 0.
- R2: Register map, by byte offset:
  - 0x00 and 0x04: configuration words.
  - 0x08: control register.
  - Channel c in 0..3: count buffer at 0x0C+12c, compare buffer at 0x10+12c, observation at 0x14+12c.
  - Channel 4: count buffer at 0x3C, observation at 0x40.
  - All buffers and configuration words read back the last value written.
- R3: Control bit layout. Channel c's group starts at bit 0 for c=0 and at bit 4c+4 for c≥1. Inside a group, the bits are run at base+0, load at base+1 and invert at base+2, with reload at base+3. Channel 4 has no invert bit, so its reload bit is bit 22 (base 20, plus 2).
- R4: A control write that moves a channel's load bit from 0 to 1 copies that channel's count buffer into its live counter. A write that leaves the load bit at 1 loads nothing.
- R5: A control write that moves a run bit from 0 to 1 lets the channel count from the next tick on. A write that moves it from 1 to 0 freezes the count.
- R6: Each tick on a running channel whose count is nonzero lowers the count by exactly 1.
- R7: A tick on a running channel whose count is 0 is an expiry. The channel's expiry output is high for the one cycle after the clock edge that took the tick.
- R8: On an expiry with the reload bit set, the count takes the count buffer value and the run bit stays 1.
- R9: On an expiry with the reload bit clear, the count stays 0 and the channel's run bit reads back 0.
- R10: When a control write lands in the same cycle as an expiry, the written control value wins over the hardware clearing of the run bit. A load caused by that write wins over the tick's decrement or reload.
- R11: Writes to unmapped offsets and to observation registers change nothing. Reads of unmapped offsets return 0.
- R12: Ticks on a stopped channel leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_in | input | NCH (5) | Per-channel count tick from the prescaler |
| expire_out | output | NCH (5) | Per-channel one-cycle expiry pulse |

## Verification
Two functions can fall in the same cycle:
- The counter's own expiry, which clears the run bit or reloads the count.
- A software write to the control register, which sets the run bit or starts a load.

The bench provokes this collision in two ways. Directed steps bring a channel to zero and then present a tick in the same cycle as a control write. A long random phase sends ticks and control writes at high density. A bench reference model judges each cycle by applying the priority from R10: written bits win over the hardware clear, and a load wins over the tick. The bench then compares expiry pulses every cycle, and compares the control word and the live counts through the bus.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int DW = 32;
  localparam int OFF_CFG0 = 'h00;
  localparam int OFF_CFG1 = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int CH_STRIDE = 12;
  localparam int CH_FIRST = 'h0C;
  localparam logic [DW-1:0] CFG0_RST = 32'h0000_0101;

  // first control bit of a channel's group
  function automatic int bit_start(input int ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction

  function automatic int bit_load(input int ch);
    return bit_start(ch) + 1;
  endfunction

  // the last channel lacks an invert bit, so its reload moves down by one
  function automatic int bit_reload(input int ch, input int last);
    return (ch == last) ? bit_start(ch) + 2 : bit_start(ch) + 3;
  endfunction

  function automatic int off_cbuf(input int ch);
    return CH_FIRST + CH_STRIDE * ch;
  endfunction

  function automatic int off_cmp(input int ch);
    return CH_FIRST + CH_STRIDE * ch + 4;
  endfunction

  function automatic int off_obs(input int ch, input int last);
    return (ch == last) ? off_cbuf(ch) + 4 : off_cbuf(ch) + 8;
  endfunction

  // next value of a live counter
  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] bufv,
                                               input logic ld, input logic adv,
                                               input logic rel);
    if (ld) return bufv;
    if (!adv) return cur;
    if (cur == '0) return rel ? bufv : '0;
    return cur - 1'b1;
  endfunction
endpackage

// File: rtl/dcb_chan.sv
module dcb_chan
  import dcb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          load,
  input  logic          reload_en,
  input  logic [DW-1:0] buf_val,
  output logic [DW-1:0] cnt,
  output logic          stop_req,
  output logic          expire_q
);
  logic expire_evt;

  assign expire_evt = tick & run & (cnt == '0);
  assign stop_req   = expire_evt & ~reload_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= expire_evt;
      cnt      <= next_count(cnt, buf_val, load, tick & run, reload_en);
    end
  end
endmodule

// File: rtl/dcb_regs.sv
module dcb_regs
  import dcb_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic [NCH-1:0][DW-1:0]  cnt_vec,
  input  logic [NCH-1:0]          stop_req,
  output logic [NCH-1:0][DW-1:0]  cbuf_vec,
  output logic [NCH-1:0]          run,
  output logic [NCH-1:0]          load,
  output logic [NCH-1:0]          reload_en
);
  localparam int LAST = NCH - 1;

  logic [DW-1:0] cfg0_q, cfg1_q, ctrl_q, stop_mask, rd_glob;
  logic          ctrl_wr;
  logic [NCH-1:0][DW-1:0] rd_part;

  assign ctrl_wr = wr_en && (addr == AW'(OFF_CTRL));

  always_comb begin
    stop_mask = '0;
    for (int i = 0; i < NCH; i++) stop_mask[bit_start(i)] = stop_req[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0_q <= CFG0_RST;
      cfg1_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en && addr == AW'(OFF_CFG0)) cfg0_q <= wdata;
      if (wr_en && addr == AW'(OFF_CFG1)) cfg1_q <= wdata;
      // a software write overrides the hardware clear of run bits
      if (ctrl_wr) ctrl_q <= wdata;
      else         ctrl_q <= ctrl_q & ~stop_mask;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int SB = bit_start(i);
    localparam int LB = bit_load(i);
    localparam int RB = bit_reload(i, LAST);
    logic [DW-1:0] cbuf_r, cmp_rd;

    assign run[i]       = ctrl_q[SB];
    assign reload_en[i] = ctrl_q[RB];
    assign load[i]      = ctrl_wr & wdata[LB] & ~ctrl_q[LB];
    assign cbuf_vec[i]  = cbuf_r;

    always_ff @(posedge clk) begin
      if (!rst_n) cbuf_r <= '0;
      else if (wr_en && addr == AW'(off_cbuf(i))) cbuf_r <= wdata;
    end

    if (i < LAST) begin : g_cmp
      logic [DW-1:0] cmp_r;
      always_ff @(posedge clk) begin
        if (!rst_n) cmp_r <= '0;
        else if (wr_en && addr == AW'(off_cmp(i))) cmp_r <= wdata;
      end
      assign cmp_rd = (addr == AW'(off_cmp(i))) ? cmp_r : '0;
    end else begin : g_nocmp
      assign cmp_rd = '0;
    end

    assign rd_part[i] = ((addr == AW'(off_cbuf(i)))     ? cbuf_r     : '0)
                      | ((addr == AW'(off_obs(i, LAST))) ? cnt_vec[i] : '0)
                      | cmp_rd;
  end

  assign rd_glob = ((addr == AW'(OFF_CFG0)) ? cfg0_q : '0)
                 | ((addr == AW'(OFF_CFG1)) ? cfg1_q : '0)
                 | ((addr == AW'(OFF_CTRL)) ? ctrl_q : '0);

  always_comb begin
    rdata = rd_glob;
    for (int i = 0; i < NCH; i++) rdata = rdata | rd_part[i];
  end
endmodule

// File: rtl/dcb_bank.sv
module dcb_bank
  import dcb_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] tick_in,
  output logic [NCH-1:0] expire_out
);
  logic [NCH-1:0][DW-1:0] cnt_vec, cbuf_vec;
  logic [NCH-1:0]         run, load, reload_en, stop_req;

  dcb_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .cnt_vec   (cnt_vec),
    .stop_req  (stop_req),
    .cbuf_vec  (cbuf_vec),
    .run       (run),
    .load      (load),
    .reload_en (reload_en)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dcb_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_in[i]),
      .run       (run[i]),
      .load      (load[i]),
      .reload_en (reload_en[i]),
      .buf_val   (cbuf_vec[i]),
      .cnt       (cnt_vec[i]),
      .stop_req  (stop_req[i]),
      .expire_q  (expire_out[i])
    );
  end
endmodule

// File: rtl/dcb_bank_chk.sv
module dcb_bank_chk
  import dcb_pkg::*;
#(
  parameter int NCH = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         tick_in,
  input logic [NCH-1:0]         expire_out,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         load,
  input logic [NCH-1:0]         reload_en,
  input logic [NCH-1:0][DW-1:0] cnt_vec
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R7: a pulse needs a tick on a running, empty channel one edge earlier
    p_expire_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      expire_out[i] |-> ($past(tick_in[i]) && $past(run[i]) && $past(cnt_vec[i]) == '0));

    // R6: a tick on a running nonzero count lowers it by one
    p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && tick_in[i] && !load[i] && cnt_vec[i] != '0)
        |=> cnt_vec[i] == $past(cnt_vec[i]) - 1'b1);

    // R12: a stopped channel without a load keeps its count
    p_hold_stopped_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !load[i]) |=> $stable(cnt_vec[i]));

    // R9: a non-reloading expiry leaves the count at zero
    p_stop_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_out[i] && !$past(reload_en[i]) && !$past(load[i])) |-> cnt_vec[i] == '0);
  end
endmodule

bind dcb_bank dcb_bank_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_in    (tick_in),
  .expire_out (expire_out),
  .run        (run),
  .load       (load),
  .reload_en  (reload_en),
  .cnt_vec    (cnt_vec)
);

// File: tb/dcb_bank_test.sv
module dcb_bank_test;
  localparam int NCH = 5;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] tick_in;
  logic [NCH-1:0] expire_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_cfg0, m_cfg1, m_ctrl;
  logic [31:0] m_cbuf [NCH];
  logic [31:0] m_cmp  [NCH];
  logic [31:0] m_cnt  [NCH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dcb_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .expire_out(expire_out)
  );

  // control bit positions and offsets, per R2 and R3
  function automatic int f_run(int c);    return 4 * c + ((c != 0) ? 4 : 0); endfunction
  function automatic int f_ld(int c);     return f_run(c) + 1; endfunction
  function automatic int f_rel(int c);    return f_run(c) + ((c == NCH - 1) ? 2 : 3); endfunction
  function automatic logic [7:0] a_cbuf(int c); return 8'(12 * c + 12); endfunction
  function automatic logic [7:0] a_cmp(int c);  return 8'(12 * c + 16); endfunction
  function automatic logic [7:0] a_obs(int c);
    return (c == NCH - 1) ? 8'(12 * c + 16) : 8'(12 * c + 20);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg0 = 32'h101; m_cfg1 = 0; m_ctrl = 0;
    for (int c = 0; c < NCH; c++) begin
      m_cbuf[c] = 0; m_cmp[c] = 0; m_cnt[c] = 0;
    end
  endtask

  // one clock with optional write and a tick vector; model updated at the edge
  task automatic step(bit w, logic [7:0] a, logic [31:0] d, logic [NCH-1:0] t);
    logic [NCH-1:0] e;
    logic [31:0] stopm, nctrl;
    logic [31:0] ncnt [NCH];
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; tick_in = t;
    stopm = 0;
    for (int c = 0; c < NCH; c++) begin
      bit runb, rel, ld;
      runb = m_ctrl[f_run(c)];
      rel  = m_ctrl[f_rel(c)];
      e[c] = t[c] && runb && (m_cnt[c] == 0);
      ld   = w && (a == 8'h08) && d[f_ld(c)] && !m_ctrl[f_ld(c)];
      if (ld) ncnt[c] = m_cbuf[c];
      else if (t[c] && runb) begin
        if (m_cnt[c] == 0) ncnt[c] = rel ? m_cbuf[c] : 32'd0;
        else ncnt[c] = m_cnt[c] - 1;
      end else ncnt[c] = m_cnt[c];
      if (e[c] && !rel) stopm[f_run(c)] = 1'b1;
    end
    nctrl = (w && a == 8'h08) ? d : (m_ctrl & ~stopm);
    @(posedge clk);
    m_ctrl = nctrl;
    for (int c = 0; c < NCH; c++) m_cnt[c] = ncnt[c];
    if (w) begin
      if (a == 8'h00) m_cfg0 = d;
      if (a == 8'h04) m_cfg1 = d;
      for (int c = 0; c < NCH; c++) begin
        if (a == a_cbuf(c)) m_cbuf[c] = d;
        if (c < NCH - 1 && a == a_cmp(c)) m_cmp[c] = d;
      end
    end
    #1;
    check("R7 expiry pulse", 32'(expire_out), 32'(e));
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_wr = 0; tick_in = '0; bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic chk_obs(int c, string req);
    logic [31:0] v;
    rd(a_obs(c), v);
    check(req, v, m_cnt[c]);
  endtask

  task automatic chk_ctrl(string req);
    logic [31:0] v;
    rd(8'h08, v);
    check(req, v, m_ctrl);
  endtask

  task automatic chk_all(string req);
    logic [31:0] v;
    rd(8'h00, v); check(req, v, m_cfg0);
    rd(8'h04, v); check(req, v, m_cfg1);
    chk_ctrl(req);
    for (int c = 0; c < NCH; c++) begin
      rd(a_cbuf(c), v); check(req, v, m_cbuf[c]);
      if (c < NCH - 1) begin rd(a_cmp(c), v); check(req, v, m_cmp[c]); end
      chk_obs(c, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7321));
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; tick_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    model_reset();

    // R1 reset state
    #1; check("R1 expiry idle", 32'(expire_out), 32'd0);
    chk_all("R1 reset value");

    // R2 map readback
    wr(8'h00, 32'hC0FF_EE01); wr(8'h04, 32'h0000_4321);
    for (int c = 0; c < NCH; c++) begin
      wr(a_cbuf(c), 32'h1000_0000 + 32'(c));
      if (c < NCH - 1) wr(a_cmp(c), 32'h2000_0000 + 32'(c));
    end
    chk_all("R2 map readback");

    // R11 unmapped and read-only offsets
    wr(8'h44, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    wr(a_obs(0), 32'hFFFF_FFFF); wr(a_obs(4), 32'hFFFF_FFFF);
    rd(8'h44, v); check("R11 unmapped read", v, 32'd0);
    rd(8'hFC, v); check("R11 unmapped read", v, 32'd0);
    chk_all("R11 ignored write");

    // R4 and R12: load while stopped, hold with bit left at 1
    wr(a_cbuf(0), 32'd5);
    wr(8'h08, 32'h0000_0002);
    chk_obs(0, "R4 load copies buffer");
    step(1'b0, 8'h00, 0, 5'b00001);
    chk_obs(0, "R12 tick while stopped");
    wr(a_cbuf(0), 32'd9);
    wr(8'h08, 32'h0000_0002);
    chk_obs(0, "R4 no load without rising edge");
    check("R4 count kept", m_cnt[0], 32'd5);

    // R3 channel 4 load bit is 21
    wr(a_cbuf(4), 32'd3);
    wr(8'h08, 32'h0020_0002);
    chk_obs(4, "R3 ch4 load bit");

    // R5 and R6: run, count, stop
    wr(8'h08, 32'h0020_0003);
    step(1'b0, 8'h00, 0, 5'b00001);
    step(1'b0, 8'h00, 0, 5'b00001);
    chk_obs(0, "R6 decrement");
    check("R6 count", m_cnt[0], 32'd3);
    wr(8'h08, 32'h0020_0002);
    step(1'b0, 8'h00, 0, 5'b00001);
    chk_obs(0, "R5 stop freezes count");

    // R7 and R9: run to expiry without reload
    wr(8'h08, 32'h0020_0003);
    for (int k = 0; k < 4; k++) step(1'b0, 8'h00, 0, 5'b00001);
    chk_ctrl("R9 run bit cleared");
    check("R9 run bit", 32'(m_ctrl[0]), 32'd0);
    chk_obs(0, "R9 count zero");

    // R8 and R3: channel 4 reload at bit 22, run at bit 20
    wr(8'h08, 32'h0070_0002);
    for (int k = 0; k < 4; k++) step(1'b0, 8'h00, 0, 5'b10000);
    chk_obs(4, "R8 reload value");
    check("R8 reload count", m_cnt[4], 32'd3);
    chk_ctrl("R8 run kept");

    // R10: write in the same cycle as a non-reload expiry on channel 0
    wr(a_cbuf(0), 32'd0);
    wr(8'h08, 32'h0070_0000);
    wr(8'h08, 32'h0070_0003);
    step(1'b1, 8'h08, 32'h0070_0003, 5'b00001);
    chk_ctrl("R10 write wins over clear");
    check("R10 run bit", 32'(m_ctrl[0]), 32'd1);
    // R10: load together with a tick
    wr(a_cbuf(0), 32'd6);
    wr(8'h08, 32'h0070_0001);
    step(1'b1, 8'h08, 32'h0070_0003, 5'b00001);
    chk_obs(0, "R10 load wins over tick");
    check("R10 loaded", m_cnt[0], 32'd6);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int k;
      logic [7:0] a;
      logic [31:0] d;
      logic [NCH-1:0] t;
      int c;
      t = NCH'($urandom);
      c = $urandom_range(0, NCH - 1);
      k = $urandom_range(0, 15);
      d = $urandom;
      case (k)
        0, 1:    begin a = 8'h08; end
        2, 3:    begin a = a_cbuf(c); d = 32'($urandom_range(0, 6)); end
        4:       begin a = a_cmp(c % (NCH - 1)); end
        5:       begin a = (c[0]) ? 8'h04 : 8'h00; end
        6:       begin a = 8'h44; end
        7:       begin a = a_obs(c); end
        default: begin a = 8'h00; end
      endcase
      step(k < 8, a, d, t);
      if (n % 16 == 15) begin
        for (int j = 0; j < NCH; j++) chk_obs(j, "R6 random count");
        chk_ctrl("R10 random control");
      end
    end
    chk_all("R11 random final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule